// File: doc/BRIEF.md
# Fetch Stall Stash Stage

This block is the second instruction fetch stage. It sits between an instruction cache that cannot be held and a decoder that can stall. The cache reads through a registered synchronous memory and is addressed straight from the next-instruction address that the first fetch stage latched, so it returns one new result every clock. The stage registers that result towards decode.

Decode raises stall. The first fetch stage sees it one cycle late, so exactly one more cache result is already on its way. The stage parks that result in a one-entry stash and keeps its own output register frozen. When stall drops, the stage first hands the parked entry to decode and then goes back to live cache data. Nothing feeds back combinationally to the cache address.

The upstream side must keep one rule: it presents at most one new valid result while a stall is pending. A result offered while the stash is already full is dropped. Flush and reset both empty the stash and invalidate the output.

Top module: `fetch_stash_stage`

## Requirements
- R1: With stall high, no flush, the stash empty and a valid cache result present, the stash takes that result's address and instruction at the clock edge, and the output does not change.
- R2: With stall low, no flush and the stash empty, the output register takes the cache valid bit, address and instruction at the edge, so the values appear one cycle after they are presented. An invalid cache result produces an invalid output.
- R3: While stall is high and flush is low, output valid, address and instruction keep their values at every edge.
- R4: At the first edge with stall low and the stash full, the output takes the stashed address and instruction with valid set, and the stash empties. From the next edge onward the output follows the live cache result.
- R5: Flush clears output valid and empties the stash at the same edge, whether or not stall is high. A stashed entry is never delivered after a flush.
- R6: Synchronous active-high reset clears output valid and empties the stash.
- R7: Decode consumes an entry in each cycle where output valid is high and stall is low. If the producer offers a new valid result only in cycles that follow a stall-low cycle, every produced address is consumed exactly once and in production order, for any stall pattern and any gaps in the cache results.
- R8: A valid cache result offered while stall is high and the stash is already full has no effect. The stash keeps its earlier entry, and that earlier entry is the one delivered on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Discard the output and stashed entries |
| stall_i | input | 1 | Decode cannot accept this cycle |
| ic_valid_i | input | 1 | Cache result valid |
| ic_addr_i | input | ADDR_W | Instruction address of the cache result |
| ic_insn_i | input | INSN_W | Instruction word of the cache result |
| dec_valid_o | output | 1 | Registered valid bit to decode |
| dec_addr_o | output | ADDR_W | Registered instruction address to decode |
| dec_insn_o | output | INSN_W | Registered instruction word to decode |

## Verification
The bench builds the stage with 32-bit addresses and 32-bit instructions. Each instruction word is derived from its address, so a swapped or stale entry shows up in both fields.

The narrower address keeps the reference model light, while several thousand random stall and cache-gap cycles exercise every overlap of stash capture, release, back-to-back stalls and bubbles. Directed sequences cover the cases that random traffic reaches only rarely: a flush that lands on a full stash, and an offer made while the stash is already full.

// File: rtl/fs_pkg.sv
package fs_pkg;

    localparam int FS_ADDR_W_DEF = 64;
    localparam int FS_INSN_W_DEF = 32;

    // Where the output register takes its next value from
    typedef enum logic [1:0] {
        FS_SEL_LIVE  = 2'd0,
        FS_SEL_STASH = 2'd1,
        FS_SEL_HOLD  = 2'd2,
        FS_SEL_CLEAR = 2'd3
    } fs_sel_e;

    typedef struct packed {
        fs_sel_e sel;
        logic    stash_load;
        logic    stash_drop;
    } fs_ctl_t;

endpackage

// File: rtl/fs_ctrl.sv
module fs_ctrl
    import fs_pkg::*;
(
    input  logic    rst_i,
    input  logic    flush_i,
    input  logic    stall_i,
    input  logic    in_vld_i,
    input  logic    stash_vld_i,
    output fs_ctl_t ctl_o
);

    fs_ctl_t ctl_d;

    always_comb begin
        ctl_d.sel        = FS_SEL_HOLD;
        ctl_d.stash_load = 1'b0;
        ctl_d.stash_drop = 1'b0;
        if (rst_i || flush_i) begin
            ctl_d.sel        = FS_SEL_CLEAR;
            ctl_d.stash_drop = 1'b1;
        end else if (stall_i) begin
            // park the one result that slips past the late stall
            ctl_d.stash_load = in_vld_i && !stash_vld_i;
        end else if (stash_vld_i) begin
            ctl_d.sel        = FS_SEL_STASH;
            ctl_d.stash_drop = 1'b1;
        end else begin
            ctl_d.sel = FS_SEL_LIVE;
        end
    end

    assign ctl_o = ctl_d;

endmodule

// File: rtl/fs_stash.sv
module fs_stash #(
    parameter int ADDR_W = fs_pkg::FS_ADDR_W_DEF,
    parameter int INSN_W = fs_pkg::FS_INSN_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              drop_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic              vld_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [INSN_W-1:0] insn_o
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [INSN_W-1:0] insn;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (drop_i) begin
            slot_d.vld = 1'b0;
        end else if (load_i) begin
            slot_d.vld  = 1'b1;
            slot_d.addr = addr_i;
            slot_d.insn = insn_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign vld_o  = slot_q.vld;
    assign addr_o = slot_q.addr;
    assign insn_o = slot_q.insn;

endmodule

// File: rtl/fs_outreg.sv
module fs_outreg
    import fs_pkg::*;
#(
    parameter int ADDR_W = FS_ADDR_W_DEF,
    parameter int INSN_W = FS_INSN_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  fs_sel_e           sel_i,
    input  logic              live_vld_i,
    input  logic [ADDR_W-1:0] live_addr_i,
    input  logic [INSN_W-1:0] live_insn_i,
    input  logic [ADDR_W-1:0] stash_addr_i,
    input  logic [INSN_W-1:0] stash_insn_i,
    output logic              vld_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [INSN_W-1:0] insn_o
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [INSN_W-1:0] insn;
    } ent_t;

    ent_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        unique case (sel_i)
            FS_SEL_LIVE: begin
                out_d.vld  = live_vld_i;
                out_d.addr = live_addr_i;
                out_d.insn = live_insn_i;
            end
            FS_SEL_STASH: begin
                out_d.vld  = 1'b1;
                out_d.addr = stash_addr_i;
                out_d.insn = stash_insn_i;
            end
            FS_SEL_CLEAR: out_d.vld = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign vld_o  = out_q.vld;
    assign addr_o = out_q.addr;
    assign insn_o = out_q.insn;

endmodule

// File: rtl/fetch_stash_stage.sv
module fetch_stash_stage
    import fs_pkg::*;
#(
    parameter int ADDR_W = FS_ADDR_W_DEF,
    parameter int INSN_W = FS_INSN_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              flush_i,
    input  logic              stall_i,
    input  logic              ic_valid_i,
    input  logic [ADDR_W-1:0] ic_addr_i,
    input  logic [INSN_W-1:0] ic_insn_i,
    output logic              dec_valid_o,
    output logic [ADDR_W-1:0] dec_addr_o,
    output logic [INSN_W-1:0] dec_insn_o
);

    fs_ctl_t           ctl;
    logic              stash_vld;
    logic [ADDR_W-1:0] stash_addr;
    logic [INSN_W-1:0] stash_insn;

    fs_ctrl u_ctrl (
        .rst_i       (rst_i),
        .flush_i     (flush_i),
        .stall_i     (stall_i),
        .in_vld_i    (ic_valid_i),
        .stash_vld_i (stash_vld),
        .ctl_o       (ctl)
    );

    fs_stash #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_stash (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (ctl.stash_load),
        .drop_i (ctl.stash_drop),
        .addr_i (ic_addr_i),
        .insn_i (ic_insn_i),
        .vld_o  (stash_vld),
        .addr_o (stash_addr),
        .insn_o (stash_insn)
    );

    fs_outreg #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_out (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .sel_i        (ctl.sel),
        .live_vld_i   (ic_valid_i),
        .live_addr_i  (ic_addr_i),
        .live_insn_i  (ic_insn_i),
        .stash_addr_i (stash_addr),
        .stash_insn_i (stash_insn),
        .vld_o        (dec_valid_o),
        .addr_o       (dec_addr_o),
        .insn_o       (dec_insn_o)
    );

endmodule

// File: rtl/fetch_stash_stage_chk.sv
module fetch_stash_stage_chk #(
    parameter int AW = 64,
    parameter int IW = 32
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          flush_i,
    input logic          stall_i,
    input logic          ic_valid_i,
    input logic [AW-1:0] ic_addr_i,
    input logic [IW-1:0] ic_insn_i,
    input logic          dec_valid_o,
    input logic [AW-1:0] dec_addr_o,
    input logic [IW-1:0] dec_insn_o,
    input logic          stash_vld
);

    // R1: parked result
    p_capture_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (stall_i && !flush_i && ic_valid_i && !stash_vld) |=> stash_vld);

    // R2: live result one cycle later
    p_pass_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && !flush_i && !stash_vld) |=>
            (dec_valid_o == $past(ic_valid_i)) &&
            (!dec_valid_o || (dec_addr_o == $past(ic_addr_i) &&
                              dec_insn_o == $past(ic_insn_i))));

    // R3: output frozen during stall
    p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (stall_i && !flush_i) |=>
            $stable(dec_valid_o) && $stable(dec_addr_o) && $stable(dec_insn_o));

    // R4: stash replayed first and emptied
    p_replay_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && !flush_i && stash_vld) |=> dec_valid_o && !stash_vld);

    // R5: flush clears both
    p_flush_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        flush_i |=> !dec_valid_o && !stash_vld);

    // R6: reset clears both
    p_reset_r6: assert property (@(posedge clk_i)
        rst_i |=> !dec_valid_o && !stash_vld);

    // R8: full stash kept while stalled
    p_keep_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (stall_i && !flush_i && stash_vld) |=> stash_vld);

endmodule

bind fetch_stash_stage fetch_stash_stage_chk #(.AW(ADDR_W), .IW(INSN_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .flush_i     (flush_i),
    .stall_i     (stall_i),
    .ic_valid_i  (ic_valid_i),
    .ic_addr_i   (ic_addr_i),
    .ic_insn_i   (ic_insn_i),
    .dec_valid_o (dec_valid_o),
    .dec_addr_o  (dec_addr_o),
    .dec_insn_o  (dec_insn_o),
    .stash_vld   (stash_vld)
);

// File: tb/fetch_stash_stage_test.sv
module fetch_stash_stage_test;

    localparam int AW = 32;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst, flush, stall, iv;
    logic [AW-1:0] ia;
    logic [IW-1:0] ii;
    logic          dv;
    logic [AW-1:0] da;
    logic [IW-1:0] di;

    always #2 clk = ~clk;

    fetch_stash_stage #(.ADDR_W(AW), .INSN_W(IW)) uut (
        .clk_i(clk), .rst_i(rst), .flush_i(flush), .stall_i(stall),
        .ic_valid_i(iv), .ic_addr_i(ia), .ic_insn_i(ii),
        .dec_valid_o(dv), .dec_addr_o(da), .dec_insn_o(di)
    );

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic [IW-1:0] i;
    } ent_t;

    // reference model state
    bit            m_v;
    logic [AW-1:0] m_a;
    logic [IW-1:0] m_i;
    ent_t          m_sq[$];
    logic [AW-1:0] ord_q[$];

    function automatic logic [IW-1:0] insn_of(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    task automatic drive(input logic v, input logic [AW-1:0] a);
        iv = v;
        ia = a;
        ii = insn_of(a);
    endtask

    task automatic step(input string tag);
        ent_t e;
        @(posedge clk);
        if (rst || flush) begin
            m_v = 1'b0;
            m_sq.delete();
        end else if (stall) begin
            if (iv && m_sq.size() == 0) begin
                e.a = ia; e.i = ii;
                m_sq.push_back(e);
            end
        end else if (m_sq.size() != 0) begin
            e = m_sq.pop_front();
            m_v = 1'b1; m_a = e.a; m_i = e.i;
        end else begin
            m_v = iv; m_a = ia; m_i = ii;
        end
        #1;
        n_cmp++;
        if (dv !== m_v || (m_v && (da !== m_a || di !== m_i))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b a=%h i=%h exp v=%0b a=%h i=%h",
                     tag, dv, da, di, m_v, m_a, m_i);
        end
    endtask

    task automatic consume_check();
        logic [AW-1:0] exp_a;
        if (dv && !stall) begin
            n_cmp++;
            if (ord_q.size() == 0) begin
                n_bad++;
                $display("FAIL R7: got a=%h exp none pending", da);
            end else begin
                exp_a = ord_q.pop_front();
                if (da !== exp_a) begin
                    n_bad++;
                    $display("FAIL R7: got a=%h exp a=%h", da, exp_a);
                end
            end
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; flush = 1'b0; stall = 1'b0;
        drive(1'b1, 32'h100);
        // R6: reset keeps output invalid even with a valid input
        step("R6");
        step("R6");
        rst = 1'b0;
        stall = 1'b1; drive(1'b0, 32'h0);
        step("R6");
        stall = 1'b0;
        // R6: nothing replayed after reset, live bubble passes
        step("R6");

        // R2: pass-through with a bubble
        drive(1'b1, 32'h1000); step("R2");
        drive(1'b0, 32'h1004); step("R2");
        drive(1'b1, 32'h1008); step("R2");

        // R1/R3: stall with one slipping result
        stall = 1'b1; drive(1'b1, 32'h100C); step("R1");
        drive(1'b0, 32'h0);                  step("R3");
        step("R3");
        // R4: release replays the parked entry, then live
        stall = 1'b0;                        step("R4");
        drive(1'b1, 32'h1010);               step("R4");

        // R8: offer while stash full is ignored
        stall = 1'b1; drive(1'b1, 32'h2000); step("R1");
        drive(1'b1, 32'hDEAD0);              step("R8");
        drive(1'b0, 32'h0);                  step("R8");
        stall = 1'b0;                        step("R8");
        drive(1'b1, 32'h2004);               step("R8");

        // R5: flush during stall with full stash
        stall = 1'b1; drive(1'b1, 32'h3000); step("R1");
        flush = 1'b1; drive(1'b0, 32'h0);    step("R5");
        flush = 1'b0; stall = 1'b0;          step("R5");
        step("R5");
        // R5: flush while unstalled drops a live result
        drive(1'b1, 32'h3004); flush = 1'b1; step("R5");
        flush = 1'b0; drive(1'b0, 32'h0);    step("R5");

        // R7: random stalls and cache gaps, exactly-once ordering
        begin
            bit            prev_stall;
            logic [AW-1:0] p_addr;
            prev_stall = 1'b0;
            p_addr     = 32'h8000;
            for (int c = 0; c < 4000; c++) begin
                stall = (($urandom % 100) < 35);
                if (!prev_stall && (($urandom % 100) < 80)) begin
                    drive(1'b1, p_addr);
                    ord_q.push_back(p_addr);
                    p_addr = p_addr + 32'd4;
                end else begin
                    drive(1'b0, 32'h0);
                end
                consume_check();
                step("R7");
                prev_stall = stall;
            end
            stall = 1'b0;
            drive(1'b0, 32'h0);
            for (int c = 0; c < 4; c++) begin
                consume_check();
                step("R7");
            end
            n_cmp++;
            if (ord_q.size() != 0) begin
                n_bad++;
                $display("FAIL R7: got %0d undelivered exp 0", ord_q.size());
            end
        end

        summary();
        $finish;
    end

endmodule